// File: doc/BRIEF.md
# Dual-Target Interrupt Cause and Mask Controller

This block gathers 32 level-sensitive interrupt sources and presents them to two separate processor targets. Each target owns a private cause register, which latches every source that has been seen high, and a private enable register, which selects the lines that may interrupt that target. A target's pending set is its cause bits ANDed with its enable bits, and the target's single interrupt output is high while that set is non-zero.

Software reaches the four registers through a single-cycle word port (address, write enable, write data, combinational read data). A handler acknowledges a line by writing a one to its cause bit. Because the sources are levels, a line that is still driven high simply latches again. A target is silenced by clearing its enable register and then writing all ones to its cause register.

Top module: `irq_dual_route`

## Requirements
- R1: Every source line i (0 to 31) maps to bit i of both cause registers and both enable registers.
- R2: The byte offsets are fixed: 0x0 is the cause register of target 0, 0x4 is the enable register of target 0, 0x8 is the cause register of target 1, and 0xC is the enable register of target 1. Registers are accessed only as whole 32-bit words.
- R3: A write to a cause register clears every bit where the write data holds a 1 and leaves every bit where it holds a 0 unchanged.
- R4: A write to an enable register replaces its whole contents with the write data. A 1 enables the line toward that target and a 0 disables it.
- R5: Any cycle in which a source is high sets that line's bit in both cause registers. A line still high after it is acknowledged therefore reads as pending again.
- R6: When a source is high in the same cycle that its cause bit is written with a 1, the bit stays set.
- R7: Each target's interrupt output (bit t of `irq_tgt`) is a register. It holds the OR of that target's cause AND enable, taken from the previous cycle, so it changes one clock after the pending set changes.
- R8: While reset is asserted and right after it, all four registers read zero and both interrupt outputs are low.
- R9: A read of a cause register returns the latched causes whatever the enable bits are. A read of any other offset returns zero, and a write to any other offset changes no register.
- R10: A write to one target's registers leaves the other target's registers and interrupt output unaffected.
- R11: With all sources low, writing zero to a target's enable register and then all ones to its cause register leaves that target with both registers at zero and its output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (4) | Byte offset of the register access |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational |
| src | input | NUM_SRC (32) | Level-sensitive interrupt source lines |
| irq_tgt | output | NUM_TGT (2) | One registered interrupt request per target |

## Verification
On every cycle the assertions check how each cause bit evolves: sources set it, write-one clears it only when the source is low, and zero bits in a write keep it. They also check that enable registers load only on their own write and otherwise stay stable, that the interrupt output trails the pending set by exactly one clock, and that unmapped offsets read zero. The address map, the independence of the two targets, and the full quiesce sequence are relations between accesses separated in time. Only the bench's directed scenarios, together with its cycle-by-cycle model under random traffic, can show those.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
   // bytes covered by one register word
   localparam int unsigned WORD_BYTES = 4;
   // bytes covered by one target's register pair
   localparam int unsigned TGT_STRIDE = 2 * WORD_BYTES;
   // address bit that picks cause or enable within a target pair
   localparam int unsigned KIND_BIT   = 2;
   // lowest address bit of the target index
   localparam int unsigned TGT_LSB    = 3;

   typedef enum logic [0:0] {
      KIND_CAUSE  = 1'b0,
      KIND_ENABLE = 1'b1
   } reg_kind_e;
endpackage

// File: rtl/irqr_addr_dec.sv
module irqr_addr_dec
   import irqr_pkg::*;
#(
   parameter int unsigned NUM_TGT = 2,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_TGT-1:0] cause_sel,
   output logic [NUM_TGT-1:0] enable_sel
);
   localparam int unsigned IDX_W = ADDR_W - TGT_LSB;

   logic [IDX_W-1:0] tgt_idx;
   reg_kind_e        kind;
   logic             aligned;

   assign tgt_idx = addr[ADDR_W-1:TGT_LSB];
   assign kind    = reg_kind_e'(addr[KIND_BIT]);
   assign aligned = (addr[1:0] == 2'b00);

   always_comb begin
      cause_sel  = '0;
      enable_sel = '0;
      for (int t = 0; t < NUM_TGT; t++) begin
         if (aligned && (tgt_idx == IDX_W'(t))) begin
            if (kind == KIND_ENABLE) enable_sel[t] = 1'b1;
            else                     cause_sel[t]  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irqr_target_bank.sv
module irqr_target_bank #(
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned NUM_SRC        = 32,
   parameter bit          IRQ_REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src,
   input  logic               wr_cause,
   input  logic               wr_enable,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_SRC-1:0] cause_q,
   output logic [NUM_SRC-1:0] enable_q,
   output logic               irq
);
   logic [NUM_SRC-1:0] ack_bits;
   logic [NUM_SRC-1:0] cause_d;
   logic [NUM_SRC-1:0] pending;

   assign ack_bits = wr_cause ? wdata[NUM_SRC-1:0] : '0;
   // a set from a live source dominates an acknowledge
   assign cause_d  = (cause_q & ~ack_bits) | src;
   assign pending  = cause_q & enable_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q  <= '0;
         enable_q <= '0;
      end else begin
         cause_q <= cause_d;
         if (wr_enable) enable_q <= wdata[NUM_SRC-1:0];
      end
   end

   generate
      if (IRQ_REGISTERED) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |pending;
         end
         assign irq = irq_q;

         assert_irq_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
            irq == $past(|(cause_q & enable_q)));
      end else begin : g_irq_comb
         assign irq = |pending;
      end
   endgenerate

   // R5 / R6: every source seen high is present in the cause word next cycle
   assert_src_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause_q & $past(src)) == $past(src)));

   // R3: acknowledged bits with a quiet source are gone next cycle
   assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cause |=> ((cause_q & $past(wdata[NUM_SRC-1:0] & ~src)) == '0));

   // R3: bits not acknowledged keep their value
   assert_zero_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause_q & $past(cause_q & ~ack_bits)) == $past(cause_q & ~ack_bits)));

   assert_enable_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_enable |=> (enable_q == $past(wdata[NUM_SRC-1:0])));

   assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_enable |=> $stable(enable_q));
endmodule

// File: rtl/irqr_rd_mux.sv
module irqr_rd_mux #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned NUM_TGT = 2
) (
   input  logic [NUM_TGT-1:0]              cause_sel,
   input  logic [NUM_TGT-1:0]              enable_sel,
   input  logic [NUM_TGT-1:0][NUM_SRC-1:0] cause_all,
   input  logic [NUM_TGT-1:0][NUM_SRC-1:0] enable_all,
   output logic [DATA_W-1:0]               rdata
);
   always_comb begin
      rdata = '0;
      for (int t = 0; t < NUM_TGT; t++) begin
         if (cause_sel[t])  rdata = rdata | DATA_W'(cause_all[t]);
         if (enable_sel[t]) rdata = rdata | DATA_W'(enable_all[t]);
      end
   end
endmodule

// File: rtl/irq_dual_route.sv
module irq_dual_route #(
   parameter int unsigned NUM_SRC        = 32,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned ADDR_W         = 4,
   parameter int unsigned NUM_TGT        = 2,
   parameter bit          IRQ_REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   input  logic [NUM_SRC-1:0] src,
   output logic [NUM_TGT-1:0] irq_tgt
);
   localparam int unsigned SPAN_BYTES = NUM_TGT * irqr_pkg::TGT_STRIDE;

   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("NUM_SRC must lie between 1 and DATA_W");
      end
      if (NUM_TGT < 1) begin : g_bad_tgt
         $error("NUM_TGT must be at least 1");
      end
      if (ADDR_W < 4 || (2 ** ADDR_W) < SPAN_BYTES) begin : g_bad_addr
         $error("ADDR_W too narrow for the register span");
      end
   endgenerate

   logic [NUM_TGT-1:0]              cause_sel;
   logic [NUM_TGT-1:0]              enable_sel;
   logic [NUM_TGT-1:0][NUM_SRC-1:0] cause_all;
   logic [NUM_TGT-1:0][NUM_SRC-1:0] enable_all;

   irqr_addr_dec #(
      .NUM_TGT (NUM_TGT),
      .ADDR_W  (ADDR_W)
   ) dec_i (
      .addr       (addr),
      .cause_sel  (cause_sel),
      .enable_sel (enable_sel)
   );

   generate
      for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
         irqr_target_bank #(
            .DATA_W         (DATA_W),
            .NUM_SRC        (NUM_SRC),
            .IRQ_REGISTERED (IRQ_REGISTERED)
         ) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .src       (src),
            .wr_cause  (wr_en & cause_sel[t]),
            .wr_enable (wr_en & enable_sel[t]),
            .wdata     (wdata),
            .cause_q   (cause_all[t]),
            .enable_q  (enable_all[t]),
            .irq       (irq_tgt[t])
         );
      end
   endgenerate

   irqr_rd_mux #(
      .DATA_W  (DATA_W),
      .NUM_SRC (NUM_SRC),
      .NUM_TGT (NUM_TGT)
   ) rd_i (
      .cause_sel  (cause_sel),
      .enable_sel (enable_sel),
      .cause_all  (cause_all),
      .enable_all (enable_all),
      .rdata      (rdata)
   );

   // R9: an offset the decoder does not claim reads as zero
   always_comb begin
      if (rst_n && !(|{cause_sel, enable_sel})) begin
         assert_unmapped_zero_R9: assert (rdata == '0);
      end
   end

   // R8: outputs quiet in the first cycle out of reset
   assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_tgt == '0));
endmodule

// File: tb/irq_dual_route_tb_top.sv
module irq_dual_route_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] src = '0;
   logic [1:0]  irq_tgt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // behavioural model state
   logic [31:0] m_cause [2];
   logic [31:0] m_mask  [2];
   logic        m_irq   [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_dual_route dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr_en   (wr_en),
      .wdata   (wdata),
      .rdata   (rdata),
      .src     (src),
      .irq_tgt (irq_tgt)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < 2; t++) begin
            m_cause[t] = '0; m_mask[t] = '0; m_irq[t] = 1'b0;
         end
      end else begin
         for (int t = 0; t < 2; t++) begin
            logic [31:0] clr;
            m_irq[t] = |(m_cause[t] & m_mask[t]);
            clr = (wr_en && addr == 4'(t*8)) ? wdata : 32'h0;
            m_cause[t] = (m_cause[t] & ~clr) | src;
            if (wr_en && addr == 4'(t*8+4)) m_mask[t] = wdata;
         end
      end
   end

   function automatic logic [31:0] exp_rd(input logic [3:0] a);
      case (a)
         4'h0: return m_cause[0];
         4'h4: return m_mask[0];
         4'h8: return m_cause[1];
         4'hC: return m_mask[1];
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check({30'h0, irq_tgt}, {30'h0, m_irq[1], m_irq[0]}, "R7 irq vs model");
         check(rdata, exp_rd(addr), "R2 rdata vs model");
      end
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
      addr = a; #1;
      check(rdata, exp, tag);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired got hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) step();
      check({30'h0, irq_tgt}, 32'h0, "R8 irq in reset");
      rst_n = 1'b1;
      step();
      check({30'h0, irq_tgt}, 32'h0, "R8 irq after reset");
      rd_check(4'h0, 32'h0, "R8 cause0");
      rd_check(4'h4, 32'h0, "R8 mask0");
      rd_check(4'h8, 32'h0, "R8 cause1");
      rd_check(4'hC, 32'h0, "R8 mask1");

      // one-cycle pulse on line 3
      src = 32'h8; step(); src = '0;
      rd_check(4'h0, 32'h8, "R5 cause0 latched");
      rd_check(4'h8, 32'h8, "R5 cause1 latched");
      check({30'h0, irq_tgt}, 32'h0, "R7 masked no irq");

      // enable line 3 for target 0
      wr(4'h4, 32'h8);
      check({30'h0, irq_tgt}, 32'h0, "R7 one cycle lag");
      step();
      check({30'h0, irq_tgt}, 32'h1, "R7 irq0 up R10 irq1 low");

      wr(4'h0, 32'h0);
      rd_check(4'h0, 32'h8, "R3 zero write keeps");
      wr(4'h0, 32'h8);
      rd_check(4'h0, 32'h0, "R3 one write clears");
      rd_check(4'h8, 32'h8, "R10 other cause kept");
      step();
      check({30'h0, irq_tgt}, 32'h0, "R7 irq drops after ack");

      // level source still high during ack
      src = 32'h20; step();
      wr(4'h0, 32'h20);
      rd_check(4'h0, 32'h20, "R6 set wins over ack");
      src = '0;
      wr(4'h0, 32'h20);
      rd_check(4'h0, 32'h0, "R5 cleared once source low");

      // all lines
      src = 32'hFFFF_FFFF; step(); src = '0;
      rd_check(4'h8, 32'hFFFF_FFFF, "R1 all lines in cause1");
      rd_check(4'h0, 32'hFFFF_FFFF, "R9 raw cause despite mask");

      // unmapped offsets
      wr(4'h1, 32'hFFFF_FFFF);
      wr(4'h6, 32'hFFFF_FFFF);
      rd_check(4'h1, 32'h0, "R9 unmapped read 1");
      rd_check(4'h2, 32'h0, "R9 unmapped read 2");
      rd_check(4'h6, 32'h0, "R9 unmapped read 6");
      rd_check(4'h4, 32'h8, "R9 mask0 untouched");
      rd_check(4'hC, 32'h0, "R9 mask1 untouched");
      rd_check(4'h0, 32'hFFFF_FFFF, "R9 cause0 untouched");

      // map and replacement
      wr(4'h4, 32'hA5A5_0000);
      wr(4'hC, 32'h0000_5A5A);
      rd_check(4'h4, 32'hA5A5_0000, "R2 mask0 offset");
      rd_check(4'hC, 32'h0000_5A5A, "R2 mask1 offset");
      wr(4'h4, 32'h0000_00F0);
      rd_check(4'h4, 32'h0000_00F0, "R4 mask replaced");

      // random traffic against the model
      for (int i = 0; i < 400; i++) begin
         src   = $urandom & $urandom & $urandom;
         addr  = 4'($urandom);
         wdata = $urandom;
         wr_en = ($urandom % 3) == 0;
         step();
      end
      wr_en = 1'b0;

      // quiesce both targets
      src = '0;
      wr(4'h4, 32'h0);
      wr(4'h0, 32'hFFFF_FFFF);
      wr(4'hC, 32'h0);
      wr(4'h8, 32'hFFFF_FFFF);
      step();
      check({30'h0, irq_tgt}, 32'h0, "R11 irq quiet");
      rd_check(4'h0, 32'h0, "R11 cause0 zero");
      rd_check(4'h4, 32'h0, "R11 mask0 zero");
      rd_check(4'h8, 32'h0, "R11 cause1 zero");
      rd_check(4'hC, 32'h0, "R11 mask1 zero");
      step();
      finish_run();
   end
endmodule